// File: doc/BRIEF.md
# Luma Quarter-Sample Interpolator

This block forms the luma prediction for one 4x4 block at quarter-sample precision. A reference window enters one row per cycle, together with the two-bit fractional parts of the motion vector. The window is only as large as the vector needs: a fractional horizontal part adds five columns and a fractional vertical part adds five rows. From that window the block builds half-sample values with a separable six-tap filter (1, -5, 20, 20, -5, 1). It then derives quarter positions by averaging two neighbouring integer or half samples.

Internally, four horizontal filters run on each incoming row. The unrounded results and the needed integer columns are kept in a small window store. During the output phase, eight vertical filters and four position selectors produce one output row of four samples per cycle. The output has a valid/ready handshake. While the block is emitting, the window feed is held off.

Top module: `luma_qpel_interp`

## Requirements
- R1: With frac_x = 0 and frac_y = 0, each output sample equals the integer reference sample at the same block position.
- R2: A half sample between integer samples in one direction is (six-tap sum + 16) >> 5, clipped to 0..255 (positions (2,0) and (0,2), given as (frac_x, frac_y)).
- R3: The centre half sample at (2,2) applies the six-tap filter vertically to the unrounded horizontal sums, then rounds as (sum + 512) >> 10 and clips to 0..255.
- R4: The other twelve fractional positions are (p + q + 1) >> 1 of the two sources given by the standard luma position table. The right-hand vertical half sample is used when frac_x = 3.
- R5: A window has 9 rows when frac_y != 0, otherwise 4. Each row is row_in lanes 0..8, with lane c at bits [8c+7:8c]. When frac_x != 0, the integer sample of block column k sits in lane k+2. Otherwise it sits in lane k, and lanes 4..8 are ignored. Likewise, when frac_y != 0 block row k sits in window row k+2. in_ready drops once the last row is accepted.
- R6: When the window rows arrive without gaps, out_valid first rises nine clock cycles after the cycle in which the first row is accepted, whatever the window size.
- R7: Exactly four output rows are emitted, from top to bottom. Block column k is on out_pix[8k+7:8k]. While out_valid is high and out_ready is low, out_valid and out_pix hold their values.
- R8: in_ready stays low whenever out_valid is high.
- R9: After reset, out_valid is low and in_ready is high.
- R10: frac_x and frac_y are taken with the first row of a window. Their values on later rows of the same window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A window row is offered |
| in_ready | output | 1 | The block accepts a window row |
| frac_x | input | 2 | Horizontal quarter-sample fraction, sampled with the first row |
| frac_y | input | 2 | Vertical quarter-sample fraction, sampled with the first row |
| row_in | input | 72 | One window row, nine 8-bit lanes |
| out_valid | output | 1 | An output row is presented |
| out_ready | input | 1 | The consumer takes the output row |
| out_pix | output | 32 | Four predicted samples of the current output row |

## Verification
A wrongly stored or misplaced window row, or a lost fraction, changes the predicted samples of the very block it belongs to. Every lane of every row is compared against a behavioural 2-D model, so such a fault is reported within at most four output cycles. A wrong row counter or latency counter shows as in_ready or out_valid changing on the wrong cycle, and that is checked cycle by cycle against the count since the first accepted row. Saturated and checkerboard windows drive the rounding and clipping paths to both ends of their range.

// File: rtl/luma_qpel_pkg.sv
package luma_qpel_pkg;

   typedef enum logic [0:0] {
      ST_LOAD = 1'b0,
      ST_EMIT = 1'b1
   } lqi_state_e;

   // saturate an integer into 0..hi
   function automatic int lqi_clip(input int v, input int hi);
      return (v < 0) ? 0 : ((v > hi) ? hi : v);
   endfunction

   // rounded mean of two samples
   function automatic int lqi_avg(input int a, input int b);
      return (a + b + 1) >>> 1;
   endfunction

endpackage

// File: rtl/lqi_tap6.sv
// Six-tap half-sample kernel (1,-5,20,20,-5,1) on signed inputs.
module lqi_tap6 #(
   parameter int IN_W  = 9,
   parameter int OUT_W = 16
) (
   input  logic signed [IN_W-1:0]  tap_i [6],
   output logic signed [OUT_W-1:0] sum_o
);
   if (OUT_W < IN_W + 6) begin : g_bad_width
      $error("lqi_tap6: OUT_W too narrow for kernel gain");
   end

   int acc;
   always_comb begin
      acc = int'(tap_i[0]) + int'(tap_i[5])
          - 5  * (int'(tap_i[1]) + int'(tap_i[4]))
          + 20 * (int'(tap_i[2]) + int'(tap_i[3]));
      sum_o = OUT_W'(acc);
   end
endmodule

// File: rtl/lqi_qpick.sv
// Picks / averages the sources for one output column per (fx, fy).
module lqi_qpick
   import luma_qpel_pkg::*;
#(
   parameter int SAMPLE_W = 8
) (
   input  logic [1:0]          fx,
   input  logic [1:0]          fy,
   input  logic [SAMPLE_W-1:0] g_px,   // integer sample
   input  logic [SAMPLE_W-1:0] r_px,   // integer sample to the right
   input  logic [SAMPLE_W-1:0] d_px,   // integer sample below
   input  logic [SAMPLE_W-1:0] b_px,   // horizontal half, same row
   input  logic [SAMPLE_W-1:0] s_px,   // horizontal half, row below
   input  logic [SAMPLE_W-1:0] v_px,   // vertical half (left or right column)
   input  logic [SAMPLE_W-1:0] j_px,   // centre half
   output logic [SAMPLE_W-1:0] px_o
);
   int g, r, d, b, s, v, j, res;

   always_comb begin
      g = int'(g_px);
      r = int'(r_px);
      d = int'(d_px);
      b = int'(b_px);
      s = int'(s_px);
      v = int'(v_px);
      j = int'(j_px);
      unique case (fy)
         2'd0: begin
            unique case (fx)
               2'd0:    res = g;
               2'd1:    res = lqi_avg(g, b);
               2'd2:    res = b;
               default: res = lqi_avg(r, b);
            endcase
         end
         2'd1: begin
            unique case (fx)
               2'd0:    res = lqi_avg(g, v);
               2'd2:    res = lqi_avg(b, j);
               default: res = lqi_avg(b, v);
            endcase
         end
         2'd2: begin
            unique case (fx)
               2'd0:    res = v;
               2'd2:    res = j;
               default: res = lqi_avg(v, j);
            endcase
         end
         default: begin
            unique case (fx)
               2'd0:    res = lqi_avg(d, v);
               2'd2:    res = lqi_avg(j, s);
               default: res = lqi_avg(v, s);
            endcase
         end
      endcase
      px_o = SAMPLE_W'(res);
   end
endmodule

// File: rtl/luma_qpel_interp.sv
module luma_qpel_interp
   import luma_qpel_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int BLK      = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   output logic                         in_ready,
   input  logic [1:0]                   frac_x,
   input  logic [1:0]                   frac_y,
   input  logic [(BLK+5)*SAMPLE_W-1:0]  row_in,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [BLK*SAMPLE_W-1:0]      out_pix
);
   localparam int TAPS = 6;
   localparam int PAD  = TAPS/2 - 1;
   localparam int WIN  = BLK + TAPS - 1;
   localparam int NC   = BLK + 1;            // stored integer columns
   localparam int HW   = SAMPLE_W + 8;       // horizontal sum width
   localparam int VW   = HW + 6;             // second-pass sum width
   localparam int RW   = $clog2(WIN + 1);
   localparam int EW   = (BLK > 1) ? $clog2(BLK) : 1;
   localparam int LAT  = WIN;
   localparam int CW   = $clog2(LAT + 1);
   localparam int MAXV = (1 << SAMPLE_W) - 1;

   if (BLK < 2 || SAMPLE_W < 2) begin : g_bad_param
      $error("luma_qpel_interp: BLK and SAMPLE_W must be at least 2");
   end

   lqi_state_e            state_q;
   logic [RW-1:0]         rows_q;
   logic [CW-1:0]         cyc_q;
   logic [EW-1:0]         emit_q;
   logic [1:0]            fx_q, fy_q;
   logic [SAMPLE_W-1:0]   canon [WIN][NC];
   logic signed [HW-1:0]  hint  [WIN][BLK];

   logic [1:0]            eff_fx, eff_fy;
   logic [RW-1:0]         rows_need, dst_row;
   logic                  accept, go_emit, shift_r;
   logic [SAMPLE_W-1:0]   crow [WIN];
   logic [SAMPLE_W-1:0]   cnew [NC];
   logic signed [HW-1:0]  hnew [BLK];
   logic [RW-1:0]         ridx [TAPS];

   // ---------------- input side ----------------
   assign eff_fx    = (rows_q == '0) ? frac_x : fx_q;
   assign eff_fy    = (rows_q == '0) ? frac_y : fy_q;
   assign rows_need = (fy_q != 2'd0) ? RW'(WIN) : RW'(BLK);
   assign dst_row   = (eff_fy != 2'd0) ? rows_q : rows_q + RW'(PAD);
   assign in_ready  = (state_q == ST_LOAD) && ((rows_q == '0) || (rows_q < rows_need));
   assign accept    = in_valid && in_ready;
   assign go_emit   = (state_q == ST_LOAD) && (rows_q != '0) &&
                      (rows_q == rows_need) && (cyc_q >= CW'(LAT));

   // place the incoming row so that block column k lands on lane k+PAD
   always_comb begin
      for (int c = 0; c < WIN; c++) begin
         if (eff_fx != 2'd0)
            crow[c] = row_in[c*SAMPLE_W +: SAMPLE_W];
         else if (c >= PAD && c < PAD + BLK)
            crow[c] = row_in[(c-PAD)*SAMPLE_W +: SAMPLE_W];
         else
            crow[c] = '0;
      end
      for (int c = 0; c < NC; c++) cnew[c] = crow[c+PAD];
   end

   // ---------------- output side ----------------
   assign out_valid = (state_q == ST_EMIT);
   assign shift_r   = (fx_q == 2'd3);

   always_comb begin
      for (int t = 0; t < TAPS; t++) ridx[t] = RW'(emit_q) + RW'(t);
   end

   for (genvar k = 0; k < BLK; k++) begin : g_col
      logic signed [SAMPLE_W:0] h_tap  [TAPS];
      logic signed [SAMPLE_W:0] vr_tap [TAPS];
      logic signed [HW-1:0]     vi_tap [TAPS];
      logic signed [HW-1:0]     h_sum, vr_sum;
      logic signed [VW-1:0]     vi_sum;
      logic [SAMPLE_W-1:0]      b_px, s_px, v_px, j_px, px;

      always_comb begin
         for (int t = 0; t < TAPS; t++) begin
            h_tap[t]  = $signed({1'b0, crow[k+t]});
            vr_tap[t] = $signed({1'b0, shift_r ? canon[ridx[t]][k+1] : canon[ridx[t]][k]});
            vi_tap[t] = hint[ridx[t]][k];
         end
      end

      // horizontal filter on the arriving row
      lqi_tap6 #(.IN_W(SAMPLE_W+1), .OUT_W(HW)) u_hf (.tap_i(h_tap), .sum_o(h_sum));
      // vertical filter on integer columns (shared left/right by the mux)
      lqi_tap6 #(.IN_W(SAMPLE_W+1), .OUT_W(HW)) u_vr (.tap_i(vr_tap), .sum_o(vr_sum));
      // vertical filter on unrounded horizontal sums (centre sample)
      lqi_tap6 #(.IN_W(HW), .OUT_W(VW)) u_vi (.tap_i(vi_tap), .sum_o(vi_sum));

      assign hnew[k] = h_sum;
      assign b_px = SAMPLE_W'(lqi_clip((int'(hint[ridx[PAD]][k])   + 16) >>> 5, MAXV));
      assign s_px = SAMPLE_W'(lqi_clip((int'(hint[ridx[PAD+1]][k]) + 16) >>> 5, MAXV));
      assign v_px = SAMPLE_W'(lqi_clip((int'(vr_sum) + 16) >>> 5, MAXV));
      assign j_px = SAMPLE_W'(lqi_clip((int'(vi_sum) + 512) >>> 10, MAXV));

      lqi_qpick #(.SAMPLE_W(SAMPLE_W)) u_pick (
         .fx   (fx_q),
         .fy   (fy_q),
         .g_px (canon[ridx[PAD]][k]),
         .r_px (canon[ridx[PAD]][k+1]),
         .d_px (canon[ridx[PAD+1]][k]),
         .b_px (b_px),
         .s_px (s_px),
         .v_px (v_px),
         .j_px (j_px),
         .px_o (px)
      );
      assign out_pix[k*SAMPLE_W +: SAMPLE_W] = px;
   end

   // ---------------- state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_LOAD;
         rows_q  <= '0;
         cyc_q   <= '0;
         emit_q  <= '0;
         fx_q    <= '0;
         fy_q    <= '0;
         for (int r = 0; r < WIN; r++) begin
            for (int c = 0; c < NC; c++)  canon[r][c] <= '0;
            for (int c = 0; c < BLK; c++) hint[r][c]  <= '0;
         end
      end else begin
         if (accept) begin
            canon[dst_row] <= cnew;
            hint[dst_row]  <= hnew;
            rows_q         <= rows_q + RW'(1);
            if (rows_q == '0) begin
               fx_q <= frac_x;
               fy_q <= frac_y;
            end
         end
         if (accept && rows_q == '0)
            cyc_q <= CW'(1);
         else if (state_q == ST_LOAD && rows_q != '0 && cyc_q < CW'(LAT))
            cyc_q <= cyc_q + CW'(1);

         if (go_emit) begin
            state_q <= ST_EMIT;
            emit_q  <= '0;
         end else if (state_q == ST_EMIT && out_ready) begin
            if (emit_q == EW'(BLK-1)) begin
               state_q <= ST_LOAD;
               rows_q  <= '0;
               emit_q  <= '0;
            end else begin
               emit_q <= emit_q + EW'(1);
            end
         end
      end
   end

   // ---------------- assertions ----------------
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(emit_q));

   p_no_feed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   p_full_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> rows_q == rows_need);

   p_frac_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rows_q != '0 |=> $stable(fx_q) && $stable(fy_q));

   p_reset_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> in_ready && !out_valid);

endmodule

// File: tb/luma_qpel_interp_tb_top.sv
module luma_qpel_interp_tb_top;
   localparam int SW  = 8;
   localparam int BLK = 4;
   localparam int WIN = 9;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [1:0]      frac_x = '0, frac_y = '0;
   logic [WIN*SW-1:0] row_in = '0;
   logic            out_valid;
   logic            out_ready = 1'b0;
   logic [BLK*SW-1:0] out_pix;

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_fail = 0;
   int win [WIN][WIN];
   int tp [6] = '{1, -5, 20, 20, -5, 1};

   luma_qpel_interp #(.SAMPLE_W(SW), .BLK(BLK)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .frac_x(frac_x), .frac_y(frac_y), .row_in(row_in),
      .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // ---------- behavioural 2-D reference ----------
   function automatic int clp(input int v);
      return (v < 0) ? 0 : ((v > 255) ? 255 : v);
   endfunction
   function automatic int av(input int a, input int b);
      return (a + b + 1) >>> 1;
   endfunction
   function automatic int half_row(input int y, input int x);
      int a = 0;
      for (int i = 0; i < 6; i++) a += tp[i] * win[y+2][x+i];
      return clp((a + 16) >>> 5);
   endfunction
   function automatic int half_col(input int y, input int x);
      int a = 0;
      for (int i = 0; i < 6; i++) a += tp[i] * win[y+i][x+2];
      return clp((a + 16) >>> 5);
   endfunction
   function automatic int half_ctr(input int y, input int x);
      int a = 0;
      for (int i = 0; i < 6; i++)
         for (int q = 0; q < 6; q++) a += tp[i] * tp[q] * win[y+i][x+q];
      return clp((a + 512) >>> 10);
   endfunction
   function automatic int ref_px(input int fx, input int fy, input int y, input int x);
      int G  = win[y+2][x+2];
      int Hr = win[y+2][x+3];
      int Md = win[y+3][x+2];
      int b  = half_row(y, x);
      int s  = half_row(y+1, x);
      int h  = half_col(y, x);
      int m  = half_col(y, x+1);
      int j  = half_ctr(y, x);
      case (fy*4 + fx)
         0:  return G;
         1:  return av(G, b);
         2:  return b;
         3:  return av(Hr, b);
         4:  return av(G, h);
         5:  return av(b, h);
         6:  return av(b, j);
         7:  return av(b, m);
         8:  return h;
         9:  return av(h, j);
         10: return j;
         11: return av(j, m);
         12: return av(Md, h);
         13: return av(h, s);
         14: return av(j, s);
         default: return av(m, s);
      endcase
   endfunction
   function automatic string req_of(input int fx, input int fy);
      if (fx == 0 && fy == 0) return "R1";
      if ((fx == 2 && fy == 0) || (fx == 0 && fy == 2)) return "R2";
      if (fx == 2 && fy == 2) return "R3";
      return "R4";
   endfunction

   // ---------- one block ----------
   task automatic run_block(input int fx, input int fy, input int pat, input bit stall);
      int nrows, t0, guard, bad;
      logic [BLK*SW-1:0] snap;
      for (int r = 0; r < WIN; r++)
         for (int c = 0; c < WIN; c++)
            case (pat)
               0: win[r][c] = $urandom_range(255);
               1: win[r][c] = 255;
               default: win[r][c] = ((r + c) % 2 == 0) ? 0 : 255;
            endcase
      nrows = (fy != 0) ? 9 : 4;
      t0 = 0;
      for (int i = 0; i < nrows; i++) begin
         @(negedge clk);
         if (i == 0) t0 = cyc;
         chk(in_ready == 1'b1, "R5 ready during window", int'(in_ready), 1);
         for (int c = 0; c < WIN; c++) begin
            int ri = (fy != 0) ? i : i + 2;
            int v;
            if (fx != 0) v = win[ri][c];
            else if (c < 4) v = win[ri][c+2];
            else v = $urandom_range(255);          // ignored lanes (R5)
            row_in[c*SW +: SW] = SW'(v);
         end
         in_valid = 1'b1;
         // later rows carry different fractions that must be ignored (R10)
         frac_x = (i == 0) ? 2'(fx) : 2'(fx ^ 3);
         frac_y = (i == 0) ? 2'(fy) : 2'((fy == 0) ? 0 : (fy ^ 3));
      end
      @(negedge clk);
      in_valid = 1'b0;
      frac_x = 2'(fx ^ 1);
      frac_y = 2'(fy ^ 2);
      chk(in_ready == 1'b0, "R5 ready after last row", int'(in_ready), 0);
      guard = 0;
      while (!out_valid && guard < 40) begin
         @(negedge clk);
         guard++;
      end
      chk(cyc == t0 + 10, "R6 latency", cyc - t0 - 1, 9);
      bad = 0;
      for (int r = 0; r < BLK; r++) begin
         if (stall && r == 1) begin
            out_ready = 1'b0;
            snap = out_pix;
            @(negedge clk);
            @(negedge clk);
            chk(out_valid == 1'b1, "R7 valid held in stall", int'(out_valid), 1);
            chk(out_pix == snap, "R7 data held in stall", int'(out_pix), int'(snap));
         end
         out_ready = 1'b1;
         chk(out_valid == 1'b1, "R7 row present", int'(out_valid), 1);
         chk(in_ready == 1'b0, "R8 feed held while emitting", int'(in_ready), 0);
         for (int k = 0; k < BLK; k++) begin
            int act = int'(out_pix[k*SW +: SW]);
            int exp = ref_px(fx, fy, r, k);
            if (act != exp) bad++;
            chk(act == exp, $sformatf("%s pos(%0d,%0d) row%0d col%0d pat%0d",
                req_of(fx, fy), fx, fy, r, k, pat), act, exp);
         end
         @(negedge clk);
      end
      out_ready = 1'b0;
      chk(out_valid == 1'b0, "R7 exactly four rows", int'(out_valid), 0);
      chk(bad == 0, "R10 fractions from first row", bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R9 reset in_ready", int'(in_ready), 1);
      for (int pat = 0; pat < 3; pat++)
         for (int fy = 0; fy < 4; fy++)
            for (int fx = 0; fx < 4; fx++)
               run_block(fx, fy, pat, (pat == 1) || ((fx + fy) % 3 == 0));
      for (int n = 0; n < 8; n++)
         run_block($urandom_range(3), $urandom_range(3), 0, n[0]);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog act=%0d exp=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule